// File: doc/BRIEF.md
# Single-Cycle RV64 Word-Arithmetic Core

This block is a small processor that fetches, decodes and retires one instruction in every clock cycle. Its instruction set is a small slice of RV64: a 64-bit add-immediate, the 32-bit "word" add, subtract and shift operations in register and immediate forms, a zero-extending word load, doubleword load and store, and a debug trap. There is no branch or jump, so the program counter moves forward by four bytes on every cycle.

The debug trap also serves as a console. Register x10 selects what the trap does. A value of 0 sends the low byte of x11 out as a character. A value of 1 stops the core. Any other value makes the trap do nothing. Decoding uses one table of masked bit patterns. Each row gives an operand format, a unit class and an operation. A word that matches no row raises a flag for that cycle and changes no state.

A host loads the instruction and data memories through a load port while reset is held. It then releases reset and watches the console, halt and invalid-instruction outputs.

Top module: `rv64w_onecycle_core`

## Requirements
- R1: While `rst_n` is low, `halt`, `char_valid` and `illegal` are 0. After release, instruction word k, at byte address 4k, executes in the k-th cycle. The first cycle is cycle 0.
- R2: Register x0 always reads as zero. A write that targets it is discarded.
- R3: The 64-bit add-immediate (opcode 0010011, funct3 000) adds the sign-extended 12-bit field in bits [31:20] to rs1 and writes rd.
- R4: Word add-immediate (opcode 0011011, funct3 000, any funct7), word add (opcode 0111011, funct7 0000000, funct3 000) and word subtract (funct7 0100000, funct3 000) work on bits [31:0]. They sign-extend the 32-bit result to 64 bits.
- R5: Word shifts take a 5-bit amount from the register or immediate. Left is funct3 001 with funct7 0000000. Right is funct3 101, with funct7 0000000 for logical and 0100000 for arithmetic. The forms are opcode 0011011 for immediate and 0111011 for register. The 32-bit result is sign-extended.
- R6: The doubleword load (opcode 0000011, funct3 011) and store (opcode 0100011, funct3 011) move 64 bits at address rs1 + sext(imm). The store immediate is {bits[31:25], bits[11:7]}. Address bits [2:0] are ignored.
- R7: The word load (opcode 0000011, funct3 110) returns the upper half of the addressed doubleword when address bit 2 is 1, and the lower half otherwise. It zero-extends the result.
- R8: The trap word 0x00100073 with x10 = 0 drives `char_valid` high for that one cycle, with `char_data` = x11[7:0]. With x10 other than 0 or 1, the trap has no visible effect.
- R9: The trap with x10 = 1 raises `halt` from the next cycle until reset. No further character, register write or invalid flag follows.
- R10: A word that matches no decode row raises `illegal` for that cycle. No register or memory write happens, and the PC advances. This includes reserved funct7 values on shifts and word arithmetic, and unused load funct3 codes.
- R11: Load-port writes take effect only while `rst_n` is low. `ld_dmem` selects data memory (1) or instruction memory (0, low 32 bits of `ld_data`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset; also opens the load port |
| ld_en | input | 1 | Load-port write enable |
| ld_dmem | input | 1 | 1 selects data memory, 0 instruction memory |
| ld_addr | input | LA_W (8) | Word index (instruction) or doubleword index (data) |
| ld_data | input | 64 | Load data |
| halt | output | 1 | Core stopped by the halting trap |
| char_valid | output | 1 | Console character strobe |
| char_data | output | 8 | Console character |
| illegal | output | 1 | Current word matched no decode row |

## Verification
The bench targets sign extension at the 32-bit boundary. A core that forgets it leaves zero upper words after SLLIW, ADDW or SUBW results with bit 31 set. These upper words are exposed by storing the value and reloading the upper half with the word load. Shift amounts of 36 catch a core that uses six shift bits. A negative store offset catches a wrong S-immediate split, and the upper-half word load catches a wrong half select or a sign-extending load. Near-miss encodings with reserved funct7 aimed at a live register show whether an invalid word leaks a write. Extra print traps after the halt show whether the core keeps running.

// File: rtl/rv64w_onecycle_core.sv
module rv64w_onecycle_core #(
  parameter int IMEM_WORDS = 256,
  parameter int DMEM_WORDS = 64,
  localparam int IA_W = $clog2(IMEM_WORDS),
  localparam int DA_W = $clog2(DMEM_WORDS),
  localparam int LA_W = (IA_W > DA_W) ? IA_W : DA_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ld_en,
  input  logic            ld_dmem,
  input  logic [LA_W-1:0] ld_addr,
  input  logic [63:0]     ld_data,
  output logic            halt,
  output logic            char_valid,
  output logic [7:0]      char_data,
  output logic            illegal
);

  localparam logic [1:0] F_I = 2'd0, F_R = 2'd1, F_S = 2'd2;
  localparam logic [3:0] OP_ADD = 4'd0, OP_ADDW = 4'd1, OP_SUBW = 4'd2, OP_SLLW = 4'd3,
                         OP_SRLW = 4'd4, OP_SRAW = 4'd5, OP_LWU = 4'd6, OP_LD = 4'd7,
                         OP_SD = 4'd8;

  logic [31:0] imem [IMEM_WORDS];
  logic [63:0] dmem [DMEM_WORDS];
  logic [63:0] rf   [32];

  logic [63:0] pc;
  logic        halted;
  logic [31:0] instr;

  logic [1:0]  fmt;
  logic        is_lsu;
  logic [3:0]  op;
  logic        hit, is_trap;

  assign instr = imem[pc[IA_W+1:2]];

  always_comb begin
    fmt = F_I; is_lsu = 1'b0; op = OP_ADD; hit = 1'b1; is_trap = 1'b0;
    casez (instr)
      32'b???????_?????_?????_000_?????_0010011: op = OP_ADD;
      32'b???????_?????_?????_000_?????_0011011: op = OP_ADDW;
      32'b0000000_?????_?????_001_?????_0011011: op = OP_SLLW;
      32'b0000000_?????_?????_101_?????_0011011: op = OP_SRLW;
      32'b0100000_?????_?????_101_?????_0011011: op = OP_SRAW;
      32'b0000000_?????_?????_001_?????_0111011: begin fmt = F_R; op = OP_SLLW; end
      32'b0000000_?????_?????_101_?????_0111011: begin fmt = F_R; op = OP_SRLW; end
      32'b0100000_?????_?????_101_?????_0111011: begin fmt = F_R; op = OP_SRAW; end
      32'b0000000_?????_?????_000_?????_0111011: begin fmt = F_R; op = OP_ADDW; end
      32'b0100000_?????_?????_000_?????_0111011: begin fmt = F_R; op = OP_SUBW; end
      32'b???????_?????_?????_110_?????_0000011: begin is_lsu = 1'b1; op = OP_LWU; end
      32'b???????_?????_?????_011_?????_0000011: begin is_lsu = 1'b1; op = OP_LD; end
      32'b???????_?????_?????_011_?????_0100011: begin fmt = F_S; is_lsu = 1'b1; op = OP_SD; end
      32'h00100073:                              is_trap = 1'b1;
      default:                                   hit = 1'b0;
    endcase
  end

  function automatic logic [63:0] sx32(input logic [31:0] v);
    return {{32{v[31]}}, v};
  endfunction

  logic [4:0]  ra_idx, rb_idx, rd;
  logic [63:0] ra, rb, imm, bsrc, alu, addr, dword, wb;
  logic [4:0]  shamt;
  logic        run, rf_we, dm_we, halt_now;

  assign rd     = instr[11:7];
  assign ra_idx = is_trap ? 5'd10 : instr[19:15];
  assign rb_idx = is_trap ? 5'd11 : instr[24:20];
  assign ra     = (ra_idx == 5'd0) ? 64'd0 : rf[ra_idx];
  assign rb     = (rb_idx == 5'd0) ? 64'd0 : rf[rb_idx];
  assign imm    = (fmt == F_S) ? {{52{instr[31]}}, instr[31:25], instr[11:7]}
                               : {{52{instr[31]}}, instr[31:20]};
  assign bsrc   = (fmt == F_R) ? rb : imm;
  assign shamt  = bsrc[4:0];
  assign addr   = ra + imm;
  assign dword  = dmem[addr[DA_W+2:3]];

  always_comb begin
    case (op)
      OP_ADDW: alu = sx32(ra[31:0] + bsrc[31:0]);
      OP_SUBW: alu = sx32(ra[31:0] - bsrc[31:0]);
      OP_SLLW: alu = sx32(ra[31:0] << shamt);
      OP_SRLW: alu = sx32(ra[31:0] >> shamt);
      OP_SRAW: alu = sx32($signed(ra[31:0]) >>> shamt);
      default: alu = ra + bsrc;
    endcase
  end

  assign wb = !is_lsu      ? alu :
              (op == OP_LD) ? dword :
              {32'd0, addr[2] ? dword[63:32] : dword[31:0]};

  assign run        = rst_n && !halted;
  assign rf_we      = run && hit && !is_trap && (op != OP_SD) && (rd != 5'd0);
  assign dm_we      = run && hit && (op == OP_SD);
  assign halt_now   = run && is_trap && (ra == 64'd1);
  assign char_valid = run && is_trap && (ra == 64'd0);
  assign char_data  = rb[7:0];
  assign illegal    = run && !hit;
  assign halt       = halted;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc     <= 64'd0;
      halted <= 1'b0;
    end else if (run) begin
      if (halt_now) halted <= 1'b1;
      else          pc     <= pc + 64'd4;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n && ld_en && !ld_dmem) imem[ld_addr[IA_W-1:0]] <= ld_data[31:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      if (ld_en && ld_dmem) dmem[ld_addr[DA_W-1:0]] <= ld_data;
    end else if (dm_we) begin
      dmem[addr[DA_W+2:3]] <= rb;
    end
  end

  always_ff @(posedge clk) begin
    if (rf_we) rf[rd] <= wb;
  end

  assert_pc_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!halted && !halt_now) |=> (pc == $past(pc) + 64'd4));
  assert_halt_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> (halted && $stable(pc) && !char_valid && !illegal));
  assert_no_write_on_bad_R10: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (!rf_we && !dm_we));
  assert_trap_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({char_valid, halt_now, illegal}));
  assert_store_no_wb_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dm_we |-> !rf_we);

endmodule

// File: tb/rv64w_onecycle_core_bench.sv
`timescale 1ns/1ps
module rv64w_onecycle_core_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_en = 1'b0, ld_dmem = 1'b0;
  logic [7:0]  ld_addr = '0;
  logic [63:0] ld_data = '0;
  logic        halt, char_valid, illegal;
  logic [7:0]  char_data;

  always #4 clk = ~clk;

  rv64w_onecycle_core u_rv64w_onecycle_core (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_dmem(ld_dmem), .ld_addr(ld_addr),
    .ld_data(ld_data), .halt(halt), .char_valid(char_valid), .char_data(char_data),
    .illegal(illegal));

  int tests = 0, fails = 0;
  logic [31:0] prog[$];
  int          dpre_idx[$];
  logic [63:0] dpre_val[$];
  logic [7:0]  got[$], exp_b[$];
  int          ill_cnt, first_char, halt_cyc;

  localparam logic [6:0] OPI = 7'b0010011, OPIW = 7'b0011011, OPW = 7'b0111011,
                         LOADOP = 7'b0000011, STOREOP = 7'b0100011;
  localparam logic [31:0] TRAP = 32'h00100073;

  function automatic logic [31:0] ei(int imm, int rs1, int f3, int rd, logic [6:0] opc);
    logic [11:0] i12 = imm[11:0];
    return {i12, rs1[4:0], f3[2:0], rd[4:0], opc};
  endfunction
  function automatic logic [31:0] er(int f7, int rs2, int rs1, int f3, int rd, logic [6:0] opc);
    return {f7[6:0], rs2[4:0], rs1[4:0], f3[2:0], rd[4:0], opc};
  endfunction
  function automatic logic [31:0] es(int imm, int rs2, int rs1, int f3, logic [6:0] opc);
    logic [11:0] i12 = imm[11:0];
    return {i12[11:5], rs2[4:0], rs1[4:0], f3[2:0], i12[4:0], opc};
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic addi(int rd, int rs, int imm); prog.push_back(ei(imm, rs, 0, rd, OPI)); endtask
  task automatic prt(int r);
    addi(11, r, 0); addi(10, 0, 0); prog.push_back(TRAP);
  endtask
  task automatic stop_core();
    addi(10, 0, 1); prog.push_back(TRAP);
  endtask

  task automatic clear();
    prog.delete(); dpre_idx.delete(); dpre_val.delete(); exp_b.delete();
  endtask

  task automatic run_prog(input bit do_load);
    got.delete(); ill_cnt = 0; first_char = -1; halt_cyc = -1;
    @(negedge clk); rst_n = 1'b0;
    if (do_load) begin
      foreach (prog[i]) begin
        ld_en = 1'b1; ld_dmem = 1'b0; ld_addr = 8'(i); ld_data = {32'd0, prog[i]};
        @(negedge clk);
      end
      foreach (dpre_idx[i]) begin
        ld_en = 1'b1; ld_dmem = 1'b1; ld_addr = 8'(dpre_idx[i]); ld_data = dpre_val[i];
        @(negedge clk);
      end
      ld_en = 1'b0;
    end
    @(negedge clk);
    chk("R1 reset outputs", {halt, char_valid, illegal}, 3'b000);
    rst_n = 1'b1;
    for (int c = 0; c < 600; c++) begin
      #2;
      if (char_valid) begin got.push_back(char_data); if (first_char < 0) first_char = c; end
      if (illegal) ill_cnt++;
      if (halt && halt_cyc < 0) halt_cyc = c;
      @(negedge clk);
      if (halt_cyc >= 0 && c > halt_cyc + 10) break;
    end
  endtask

  task automatic cmp(string req);
    chk({req, " char count"}, 64'(got.size()), 64'(exp_b.size()));
    foreach (exp_b[i])
      if (i < got.size()) chk($sformatf("%s char %0d", req, i), 64'(got[i]), 64'(exp_b[i]));
  endtask

  task automatic t_reset_order();
    clear();
    addi(11, 0, 8'h41); addi(10, 0, 0); prog.push_back(TRAP); stop_core();
    run_prog(1);
    exp_b.push_back(8'h41); cmp("R8 first char");
    chk("R1 first char cycle", 64'(first_char), 64'd2);
    chk("R9 halt cycle", 64'(halt_cyc), 64'd5);
  endtask

  task automatic t_preload_ignored();
    @(negedge clk);
    ld_en = 1'b1; ld_dmem = 1'b0; ld_addr = 8'd0; ld_data = 64'd0;
    @(negedge clk); ld_en = 1'b0;
    exp_b.delete(); exp_b.push_back(8'h41);
    run_prog(0);
    cmp("R11 load outside reset ignored");
    chk("R11 no illegal", 64'(ill_cnt), 64'd0);
  endtask

  task automatic t_x0();
    clear();
    addi(0, 0, 55); prt(0);
    addi(5, 0, 9); prog.push_back(er(0, 5, 0, 0, 0, OPW)); prt(0);
    stop_core(); run_prog(1);
    exp_b.push_back(8'h00); exp_b.push_back(8'h00); cmp("R2 x0 zero");
  endtask

  task automatic t_addi();
    clear();
    addi(5, 0, -1); prt(5);
    prog.push_back(es(0, 5, 0, 3, STOREOP)); prog.push_back(ei(4, 0, 6, 7, LOADOP)); prt(7);
    addi(8, 0, 2047); prog.push_back(es(8, 8, 0, 3, STOREOP));
    prog.push_back(ei(12, 0, 6, 9, LOADOP)); prt(9);
    addi(12, 5, -2048); prt(12);
    stop_core(); run_prog(1);
    exp_b = '{8'hFF, 8'hFF, 8'h00, 8'hFF};
    cmp("R3 addi sign-extend");
  endtask

  task automatic t_word_ops();
    clear();
    addi(5, 0, 1);
    prog.push_back(ei(31, 5, 1, 6, OPIW)); prt(6);
    prog.push_back(es(0, 6, 0, 3, STOREOP)); prog.push_back(ei(4, 0, 6, 7, LOADOP)); prt(7);
    prog.push_back(ei(12'h400 + 4, 6, 5, 7, OPIW));
    prog.push_back(ei(24, 7, 5, 8, OPIW)); prt(8);
    addi(9, 0, 36);
    prog.push_back(er(0, 9, 6, 5, 12, OPW));
    prog.push_back(ei(24, 12, 5, 13, OPIW)); prt(13);
    prog.push_back(er(0, 9, 5, 1, 14, OPW)); prt(14);
    prog.push_back(er(32, 9, 6, 5, 15, OPW));
    prog.push_back(ei(24, 15, 5, 15, OPIW)); prt(15);
    addi(16, 0, 2047);
    prog.push_back(ei(20, 16, 1, 17, OPIW));
    prog.push_back(er(0, 17, 17, 0, 18, OPW));
    prog.push_back(es(8, 18, 0, 3, STOREOP)); prog.push_back(ei(12, 0, 6, 19, LOADOP)); prt(19);
    prog.push_back(ei(24, 18, 5, 20, OPIW)); prt(20);
    prog.push_back(er(32, 16, 0, 0, 21, OPW)); prt(21);
    prog.push_back(es(16, 21, 0, 3, STOREOP)); prog.push_back(ei(20, 0, 6, 22, LOADOP)); prt(22);
    prog.push_back(ei(12'h100, 17, 0, 23, OPIW));
    prog.push_back(ei(8, 23, 5, 23, OPIW)); prt(23);
    stop_core(); run_prog(1);
    exp_b = '{8'h00, 8'hFF, 8'hF8, 8'h08, 8'h10, 8'hF8, 8'hFF, 8'hFF, 8'h01, 8'hFF, 8'h01};
    cmp("R4 R5 word arithmetic and shifts");
  endtask

  task automatic t_memory();
    clear();
    dpre_idx.push_back(2); dpre_val.push_back(64'h1122334455667788);
    addi(5, 0, 8);
    prog.push_back(ei(8, 5, 3, 6, LOADOP)); prt(6);
    prog.push_back(ei(20, 0, 6, 7, LOADOP)); prt(7);
    prog.push_back(ei(16, 0, 6, 8, LOADOP)); prt(8);
    prog.push_back(es(24, 7, 0, 3, STOREOP)); prog.push_back(ei(28, 0, 6, 9, LOADOP)); prt(9);
    addi(12, 0, 64);
    prog.push_back(es(-24, 6, 12, 3, STOREOP));
    prog.push_back(ei(40, 0, 3, 13, LOADOP)); prt(13);
    prog.push_back(ei(44, 0, 6, 14, LOADOP)); prt(14);
    prog.push_back(ei(23, 0, 3, 15, LOADOP)); prt(15);
    stop_core(); run_prog(1);
    exp_b = '{8'h88, 8'h44, 8'h88, 8'h00, 8'h88, 8'h44, 8'h88};
    cmp("R6 R7 loads and stores");
  endtask

  task automatic t_trap_halt();
    clear();
    addi(11, 0, 8'h5A); addi(10, 0, 2); prog.push_back(TRAP);
    addi(10, 0, 0); prog.push_back(TRAP); prog.push_back(TRAP);
    stop_core();
    prt(11); prog.push_back(32'd0); addi(11, 0, 1); prt(11);
    run_prog(1);
    exp_b = '{8'h5A, 8'h5A};
    cmp("R8 R9 trap select and freeze");
    chk("R9 no illegal after halt", 64'(ill_cnt), 64'd0);
    chk("R9 halt held", 64'(halt), 64'd1);
    chk("R9 halt cycle", 64'(halt_cyc), 64'd8);
  endtask

  task automatic t_illegal();
    clear();
    addi(5, 0, 3);
    prog.push_back(32'd0);
    prog.push_back(er(1, 5, 5, 0, 5, OPW));
    prog.push_back(ei(12'h020 + 1, 5, 1, 5, OPIW));
    prog.push_back(ei(0, 0, 7, 5, LOADOP));
    prog.push_back(es(0, 5, 0, 2, STOREOP));
    prt(5);
    addi(6, 0, 7); prog.push_back(ei(0, 0, 3, 6, LOADOP)); prt(6);
    stop_core(); run_prog(1);
    exp_b = '{8'h03, 8'h00};
    cmp("R10 invalid word has no effect");
    chk("R10 illegal count", 64'(ill_cnt), 64'd5);
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("  [TB] %0d tests run, %0d failed", tests + 1, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset_order();
    t_preload_ignored();
    t_x0();
    t_addi();
    t_word_ops();
    t_memory();
    t_trap_halt();
    t_illegal();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule